// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block produces one pulse-width modulated output per channel from a small set of memory-mapped registers. Each channel owns a counter that runs from zero up to its period value, clocked through a power-of-two prescaler. The output stays at its inactive level while the counter is below the duty value. It is at its active level from the duty value to the end of the period. A polarity bit selects whether the active level is high or low.

Software starts channels by writing ones to a set register and stops them by writing ones to a clear register. A stop waits for the running period to finish, so the last pulse is never cut short. While a channel runs, new duty and period values are written to shadow registers. The channel moves them into its live registers only when a period wraps, which avoids glitched pulses. Each wrap also raises a per-channel flag. Software collects the flags with a read that returns them and clears them in the same access.

The bus has a write strobe, a read strobe, a 12-bit byte address and 32-bit data. Read data is combinational from the address. The read strobe only triggers the clear-on-read side effect.

Top module: `pwm_mc`

## Requirements
- R1: After reset every channel is stopped, every output is low, and the status (0x0C) and flag (0x1C) registers read zero.
- R2: Writing a one to bit n at 0x04 starts stopped channel n, and writing a one to bit n at 0x08 requests a stop. Zero bits in either write have no effect.
- R3: Status bit n at 0x0C reads one while channel n runs. After a stop request it stays one until the current period ends, and the channel then stops with its counter cleared.
- R4: A started channel counts 0..P-1, where P is its period. The output is inactive for counts below the duty D and active for counts D..P-1, and the first period starts at count zero.
- R5: Mode bits [3:0] hold a prescale code s, and the counter advances once every 2^s clocks. Codes above 10 behave as 10.
- R6: With mode bit 9 clear the active level is high, and with it set the active level is low. A stopped channel drives its inactive level.
- R7: A duty of zero gives an output active for the whole period. A duty equal to or above the period gives an output inactive for the whole period.
- R8: A value written to the duty shadow register (channel offset 0x08) is held and becomes the live duty at the next period wrap.
- R9: A value written to the period shadow register (channel offset 0x10) is held and becomes the live period at the next period wrap.
- R10: Channel n's window starts at 0x200 + n*0x20, with mode at 0x00, duty at 0x04 and period at 0x0C. Writes to these three load at once while the channel is stopped and are ignored while it runs, and reads return the live values.
- R11: Flag bit n at 0x1C is set each time running channel n wraps into a new period without stopping. A read returns the flags and clears them, but a flag raised in the same cycle as the read is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clear-on-read side effect) |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| pwm_o | output | 4 | One modulated output per channel |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counters and a prescale ceiling of 10. Because the ceiling is 10, the clamp of an out-of-range prescale code shows up within about a thousand clocks. Short periods of four to eight counts let the cycle-exact waveform be predicted over several wraps. With them, a shadow write landing mid-period, a stop request deferred to the period end, and the flag raised at each wrap can all be checked in a few dozen cycles per channel. The four channels allow checks that one channel's activity leaves another's output untouched.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int OFS_SET   = 'h004;
    localparam int OFS_CLR   = 'h008;
    localparam int OFS_STAT  = 'h00C;
    localparam int OFS_FLAG  = 'h01C;
    localparam int CH_BASE   = 'h200;
    localparam int CH_STRIDE = 'h20;
    localparam int WIN_W     = $clog2(CH_STRIDE);
    localparam int POL_BIT   = 9;

    typedef enum logic [2:0] {
        CR_NONE,
        CR_MODE,
        CR_DUTY,
        CR_DUTY_SH,
        CR_PRD,
        CR_PRD_SH
    } chreg_e;

    function automatic chreg_e decode_reg(input logic [WIN_W-1:0] off);
        case (off)
            5'h00:   return CR_MODE;
            5'h04:   return CR_DUTY;
            5'h08:   return CR_DUTY_SH;
            5'h0C:   return CR_PRD;
            5'h10:   return CR_PRD_SH;
            default: return CR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pwm_presc.sv
module pwm_presc #(
    parameter int PRE_W   = 4,
    parameter int PRE_MAX = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PRE_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int PC_W = PRE_MAX + 1;

    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } pre_t;

    pre_t            s_d, s_q;
    logic [PC_W-1:0] lim;

    always_comb begin
        if (int'(sel_i) > PRE_MAX) lim = PC_W'((1 << PRE_MAX) - 1);
        else                       lim = PC_W'((1 << int'(sel_i)) - 1);
        tick_o = run_i && (s_q.cnt == lim);
        s_d    = s_q;
        if (!run_i || tick_o) s_d.cnt = '0;
        else                  s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int PRE_W   = 4,
    parameter int PRE_MAX = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  chreg_e           wsel_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic             run_o,
    output logic             wrap_o,
    output logic             pwm_o,
    output logic [PRE_W-1:0] psel_o,
    output logic             pol_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] dty_o,
    output logic [CNT_W-1:0] dty_sh_o,
    output logic [CNT_W-1:0] prd_o,
    output logic [CNT_W-1:0] prd_sh_o
);
    typedef struct packed {
        logic             run;
        logic             stop_req;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] prd;
        logic [CNT_W-1:0] dty;
        logic [CNT_W-1:0] prd_sh;
        logic [CNT_W-1:0] dty_sh;
        logic             prd_pend;
        logic             dty_pend;
        logic [PRE_W-1:0] psel;
        logic             pol;
    } ch_t;

    ch_t            s_d, s_q;
    logic           tick;
    logic           at_end;
    logic [CNT_W:0] nxt;

    pwm_presc #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (s_q.run),
        .sel_i  (s_q.psel),
        .tick_o (tick)
    );

    always_comb begin
        s_d    = s_q;
        wrap_o = 1'b0;
        nxt    = {1'b0, s_q.cnt} + (CNT_W+1)'(1);
        at_end = tick && (nxt >= {1'b0, s_q.prd});
        if (!s_q.run) begin
            if (start_i) begin
                s_d.run      = 1'b1;
                s_d.cnt      = '0;
                s_d.stop_req = 1'b0;
            end
        end else begin
            if (stop_i)  s_d.stop_req = 1'b1;
            if (start_i) s_d.stop_req = 1'b0;
            if (at_end) begin
                s_d.cnt = '0;
                if (s_q.dty_pend) begin
                    s_d.dty      = s_q.dty_sh;
                    s_d.dty_pend = 1'b0;
                end
                if (s_q.prd_pend) begin
                    s_d.prd      = s_q.prd_sh;
                    s_d.prd_pend = 1'b0;
                end
                if (s_d.stop_req) begin
                    s_d.run      = 1'b0;
                    s_d.stop_req = 1'b0;
                end else begin
                    wrap_o = 1'b1;
                end
            end else if (tick) begin
                s_d.cnt = nxt[CNT_W-1:0];
            end
        end
        case (wsel_i)
            CR_MODE: if (!s_q.run) begin
                s_d.psel = wdata_i[PRE_W-1:0];
                s_d.pol  = wdata_i[POL_BIT];
            end
            CR_DUTY: if (!s_q.run) s_d.dty = wdata_i;
            CR_PRD:  if (!s_q.run) s_d.prd = wdata_i;
            CR_DUTY_SH: begin
                s_d.dty_sh   = wdata_i;
                s_d.dty_pend = 1'b1;
            end
            CR_PRD_SH: begin
                s_d.prd_sh   = wdata_i;
                s_d.prd_pend = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign run_o    = s_q.run;
    assign pwm_o    = (s_q.run && (s_q.cnt >= s_q.dty)) ^ s_q.pol;
    assign psel_o   = s_q.psel;
    assign pol_o    = s_q.pol;
    assign cnt_o    = s_q.cnt;
    assign dty_o    = s_q.dty;
    assign dty_sh_o = s_q.dty_sh;
    assign prd_o    = s_q.prd;
    assign prd_sh_o = s_q.prd_sh;
endmodule

// File: rtl/pwm_mc.sv
module pwm_mc
    import pwm_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CNT_W   = 16,
    parameter int PRE_W   = 4,
    parameter int PRE_MAX = 10,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pwm_o
);
    localparam int IDX_W = ADDR_W - WIN_W;

    typedef struct packed {
        logic [NCH-1:0] flag;
    } top_t;

    top_t                       s_d, s_q;
    logic [NCH-1:0]             start_w, stop_w, run_w, wrap_w, pol_w, flag_w;
    logic [NCH-1:0][PRE_W-1:0]  psel_w;
    logic [NCH-1:0][CNT_W-1:0]  cnt_w, dty_w, dsh_w, prd_w, psh_w;
    chreg_e                     wsel_w [NCH];
    logic [ADDR_W-1:0]          rel;
    logic [IDX_W-1:0]           idx;
    logic                       in_win;
    chreg_e                     rsel;
    logic                       unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];
    assign rel       = bus_addr - ADDR_W'(CH_BASE);
    assign idx       = rel[ADDR_W-1:WIN_W];
    assign in_win    = (bus_addr >= ADDR_W'(CH_BASE)) && (int'(idx) < NCH);
    assign rsel      = decode_reg(rel[WIN_W-1:0]);

    always_comb begin
        start_w = (bus_wr && bus_addr == ADDR_W'(OFS_SET)) ? bus_wdata[NCH-1:0] : '0;
        stop_w  = (bus_wr && bus_addr == ADDR_W'(OFS_CLR)) ? bus_wdata[NCH-1:0] : '0;
        for (int n = 0; n < NCH; n++) begin
            wsel_w[n] = (bus_wr && in_win && idx == IDX_W'(n)) ? rsel : CR_NONE;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (start_w[g]),
            .stop_i   (stop_w[g]),
            .wsel_i   (wsel_w[g]),
            .wdata_i  (bus_wdata[CNT_W-1:0]),
            .run_o    (run_w[g]),
            .wrap_o   (wrap_w[g]),
            .pwm_o    (pwm_o[g]),
            .psel_o   (psel_w[g]),
            .pol_o    (pol_w[g]),
            .cnt_o    (cnt_w[g]),
            .dty_o    (dty_w[g]),
            .dty_sh_o (dsh_w[g]),
            .prd_o    (prd_w[g]),
            .prd_sh_o (psh_w[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (bus_rd && bus_addr == ADDR_W'(OFS_FLAG)) s_d.flag = wrap_w;
        else                                          s_d.flag = s_q.flag | wrap_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_w = s_q.flag;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_STAT)) begin
            bus_rdata[NCH-1:0] = run_w;
        end else if (bus_addr == ADDR_W'(OFS_FLAG)) begin
            bus_rdata[NCH-1:0] = s_q.flag;
        end else if (in_win) begin
            for (int n = 0; n < NCH; n++) begin
                if (idx == IDX_W'(n)) begin
                    case (rsel)
                        CR_MODE: begin
                            bus_rdata[PRE_W-1:0] = psel_w[n];
                            bus_rdata[POL_BIT]   = pol_w[n];
                        end
                        CR_DUTY:    bus_rdata[CNT_W-1:0] = dty_w[n];
                        CR_DUTY_SH: bus_rdata[CNT_W-1:0] = dsh_w[n];
                        CR_PRD:     bus_rdata[CNT_W-1:0] = prd_w[n];
                        CR_PRD_SH:  bus_rdata[CNT_W-1:0] = psh_w[n];
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/pwm_mc_chk.sv
module pwm_mc_chk
    import pwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 12
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_rd,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [NCH-1:0]            flag,
    input logic [NCH-1:0]            wrap,
    input logic [NCH-1:0]            run,
    input logic [NCH-1:0]            pol,
    input logic [NCH-1:0]            pwm,
    input logic [NCH-1:0][CNT_W-1:0] cnt,
    input logic [NCH-1:0][CNT_W-1:0] dty,
    input logic [NCH-1:0][CNT_W-1:0] prd
);
    p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFS_FLAG)) |=> (flag == $past(wrap)));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_flag_on_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[g] |=> flag[g]);

        p_start_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run[g]) |-> (cnt[g] == '0));

        p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !run[g] |-> (pwm[g] == pol[g]));

        p_stop_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(run[g]) |->
                (({1'b0, $past(cnt[g])} + (CNT_W+1)'(1)) >= {1'b0, $past(prd[g])}));

        p_duty_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (run[g] && $past(run[g]) && cnt[g] != '0) |-> $stable(dty[g]));
    end
endmodule

bind pwm_mc pwm_mc_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .flag     (flag_w),
    .wrap     (wrap_w),
    .run      (run_w),
    .pol      (pol_w),
    .pwm      (pwm_o),
    .cnt      (cnt_w),
    .dty      (dty_w),
    .prd      (prd_w)
);

// File: tb/tb_pwm_mc.sv
`timescale 1ns/1ps
module tb_pwm_mc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;
    int          n_chk = 0;
    int          n_fail = 0;

    localparam logic [11:0] A_SET  = 12'h004;
    localparam logic [11:0] A_CLR  = 12'h008;
    localparam logic [11:0] A_STAT = 12'h00C;
    localparam logic [11:0] A_FLAG = 12'h01C;

    always #10 clk = ~clk;

    pwm_mc dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    function automatic logic [11:0] ca(int ch, int off);
        return 12'(32'h200 + ch * 32 + off);
    endfunction

    function automatic bit ex(int k, int p, int d, int s, bit pol);
        return (((k >> s) % p) >= d) ^ pol;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic setup(int ch, int mode, int p, int d);
        wr(ca(ch, 'h00), 32'(mode));
        wr(ca(ch, 'h0C), 32'(p));
        wr(ca(ch, 'h04), 32'(d));
    endtask

    task automatic stop_wait(int ch);
        logic [31:0] v;
        wr(A_CLR, 32'(1 << ch));
        for (int i = 0; i < 3000; i++) begin
            rd(A_STAT, v);
            if (!v[ch]) break;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_STAT, v); chk(v == 0, "R1 status", int'(v), 0);
        rd(A_FLAG, v); chk(v == 0, "R1 flags", int'(v), 0);
        chk(pwm_o == 4'h0, "R1 outputs", int'(pwm_o), 0);
    endtask

    task automatic t_direct;
        logic [31:0] v;
        setup(0, 0, 8, 3);
        rd(ca(0, 'h04), v); chk(v == 3, "R10 duty readback", int'(v), 3);
        rd(ca(0, 'h0C), v); chk(v == 8, "R10 period readback", int'(v), 8);
        wr(A_SET, 32'h0);
        rd(A_STAT, v); chk(v == 0, "R2 zero write starts nothing", int'(v), 0);
    endtask

    task automatic t_wave;
        logic [31:0] v;
        rd(A_FLAG, v);
        wr(A_SET, 32'h1);
        for (int k = 0; k < 27; k++) begin
            @(negedge clk);
            if (k < 24) chk(pwm_o[0] == ex(k, 8, 3, 0, 0), "R4 waveform", int'(pwm_o[0]), int'(ex(k, 8, 3, 0, 0)));
            else        chk(pwm_o[0] == 1'b0, "R3 inactive after stop", int'(pwm_o[0]), 0);
            if (k == 12) chk(pwm_o[1] == 1'b0, "R2 other channel idle", int'(pwm_o[1]), 0);
            if (k == 20) chk(bus_rdata[0] == 1'b1, "R3 status held until period end", int'(bus_rdata[0]), 1);
            if (k == 25) chk(bus_rdata[0] == 1'b0, "R3 status cleared after stop", int'(bus_rdata[0]), 0);
            if (k == 18) begin
                bus_wr = 1'b1; bus_addr = A_CLR; bus_wdata = 32'h1;
            end else begin
                bus_wr = 1'b0; bus_addr = A_STAT;
            end
        end
        rd(A_FLAG, v); chk(v == 1, "R11 wrap flag", int'(v), 1);
        rd(A_FLAG, v); chk(v == 0, "R11 cleared by read", int'(v), 0);
    endtask

    task automatic t_polar;
        setup(2, (1 << 9) | 1, 5, 2);
        @(negedge clk);
        chk(pwm_o[2] == 1'b1, "R6 idle level inverted", int'(pwm_o[2]), 1);
        wr(A_SET, 32'h4);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            chk(pwm_o[2] == ex(k, 5, 2, 1, 1), "R5 R6 prescaled inverted", int'(pwm_o[2]), int'(ex(k, 5, 2, 1, 1)));
        end
        stop_wait(2);
        @(negedge clk);
        chk(pwm_o[2] == 1'b1, "R6 stopped inverted level", int'(pwm_o[2]), 1);
    endtask

    task automatic t_buf_duty;
        logic [31:0] v;
        setup(1, 0, 8, 2);
        wr(A_SET, 32'h2);
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            chk(pwm_o[1] == ex(k, 8, (k < 8) ? 2 : 6, 0, 0), "R8 duty shadow",
                int'(pwm_o[1]), int'(ex(k, 8, (k < 8) ? 2 : 6, 0, 0)));
            bus_wr = (k == 3); bus_addr = ca(1, 'h08); bus_wdata = 32'd6;
        end
        wr(ca(1, 'h0C), 32'd100);
        rd(ca(1, 'h0C), v); chk(v == 8, "R10 period write ignored while running", int'(v), 8);
        rd(ca(1, 'h04), v); chk(v == 6, "R8 live duty after wrap", int'(v), 6);
        stop_wait(1);
    endtask

    task automatic t_buf_prd;
        setup(1, 0, 4, 1);
        wr(A_SET, 32'h2);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (k < 4) chk(pwm_o[1] == ex(k, 4, 1, 0, 0), "R9 old period", int'(pwm_o[1]), int'(ex(k, 4, 1, 0, 0)));
            else       chk(pwm_o[1] == ex(k - 4, 6, 1, 0, 0), "R9 new period", int'(pwm_o[1]), int'(ex(k - 4, 6, 1, 0, 0)));
            bus_wr = (k == 1); bus_addr = ca(1, 'h10); bus_wdata = 32'd6;
        end
        stop_wait(1);
    endtask

    task automatic t_edges;
        setup(3, 0, 4, 0);
        wr(A_SET, 32'h8);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(pwm_o[3] == 1'b1, "R7 duty zero always active", int'(pwm_o[3]), 1);
        end
        stop_wait(3);
        wr(ca(3, 'h04), 32'd9);
        wr(A_SET, 32'h8);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(pwm_o[3] == 1'b0, "R7 duty above period never active", int'(pwm_o[3]), 0);
        end
        stop_wait(3);
    endtask

    task automatic t_clamp;
        setup(3, 15, 2, 1);
        wr(A_SET, 32'h8);
        for (int k = 0; k < 1026; k++) begin
            @(negedge clk);
            if (k == 0 || k == 1023) chk(pwm_o[3] == 1'b0, "R5 clamp low", int'(pwm_o[3]), 0);
            if (k == 1024)           chk(pwm_o[3] == 1'b1, "R5 clamp high", int'(pwm_o[3]), 1);
        end
        stop_wait(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_direct;
        t_wave;
        t_polar;
        t_buf_duty;
        t_buf_prd;
        t_edges;
        t_clamp;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule